// File: doc/BRIEF.md
# Final-Block Message Padder

This unit sits between a word-wide message source and the compression core of a hash that works on 512-bit blocks. Message words pass through it one per handshake and form 16-word blocks. The first message bit sits at bit 0 of the first word, and bit 32 of the message sits at bit 0 of the second word. The source flags the final word and gives the number of valid bits in it, from 1 to 32.

For the final word, the unit clears the bits above the valid count and sets a single one bit just above the last message bit. It then fills with zero words. The last two words of the final block carry the 64-bit message length. If that length cannot fit behind the terminating bit in the current block, the unit produces one more block made only of padding. While padding words are being produced, no input is accepted.

States and transitions of the controller:
- `ST_MSG` passes message words through. On acceptance of the final word it goes to one of three states:
  - `ST_ONE` when the final word is full.
  - `ST_LEN_LO` when the next word index is 14.
  - `ST_ZERO` otherwise.
- `ST_ONE` emits the word that holds only the terminating bit. It then goes to `ST_LEN_LO` or `ST_ZERO` by the same index test.
- `ST_ZERO` emits zero words until the next index is 14, then goes to `ST_LEN_LO`.
- `ST_LEN_LO` emits the low length half and goes to `ST_LEN_HI`.
- `ST_LEN_HI` emits the high length half, marks the end and returns to `ST_MSG`.

Every transition is taken only on an output handshake.

Top module: `pad_final_block`

## Requirements
- R1: After reset `out_valid` is low while `in_valid` is low, and `in_ready` follows `out_ready`. The block index and the length both start at zero.
- R2: A word with `in_last` low is passed to `out_data` unchanged in the same cycle. It is transferred when both `in_valid` and `out_ready` are high.
- R3: For a final word with valid count N below 32, output bits N-1..0 equal the input bits, bit N is 1, and bits 31..N+1 are 0.
- R4: For a final word with N equal to 32, the word passes unchanged. It is followed by a word of value 0x00000001.
- R5: After the word holding the terminating bit, zero words are emitted until the word index within the block (0..15) reaches 14.
- R6: The word at index 14 of the final block carries length bits 31..0, and the word at index 15 carries bits 63..32. The length is 32 times the number of non-final words, plus N.
- R7: When the terminating bit falls in word 14 or 15 of a block, the rest of that block is zero-filled. A further 16-word block of zeros and the length follows.
- R8: `out_last` is high only on the word at index 15 of the final block of a message.
- R9: From the transfer of the final word until the last length word is transferred, `in_ready` stays low. Under a stall (`out_ready` low), `out_valid` stays high and `out_data` stays unchanged.
- R10: After the last length word, the next message starts at block index 0, with its length counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source has a message word |
| in_ready | output | 1 | Unit accepts a message word |
| in_data | input | 32 | Message word, first bit at bit 0 |
| in_last | input | 1 | Word is the final message word |
| in_nbits | input | 6 | Valid bits in the final word, 1..32 |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Core accepts the output word |
| out_data | output | 32 | Message or padding word |
| out_last | output | 1 | Last word of the final block |

## Verification
The assertions assume that `in_nbits` lies in 1..32 whenever a final word is offered. They also assume the source holds its word stable until it is taken. The stimulus keeps to both. Valid counts are drawn only from that range, and the driver task changes `in_data`, `in_last` and `in_nbits` only after the word has been accepted. Messages are sized so the terminating bit lands at block indices 0, 13, 14 and 15, and they also span more than one block. They run with `out_ready` always high, with `out_ready` randomly throttled, and with a long hold while padding is being produced.

// File: rtl/pad_pkg.sv
package pad_pkg;

    typedef enum logic [2:0] {
        ST_MSG    = 3'd0,
        ST_ONE    = 3'd1,
        ST_ZERO   = 3'd2,
        ST_LEN_LO = 3'd3,
        ST_LEN_HI = 3'd4
    } pad_state_e;

endpackage

// File: rtl/pad_tail_mask.sv
// Clears bits above the valid count of the final word and places the
// terminating one bit directly above the last message bit.
module pad_tail_mask #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W) + 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic [WORD_W-1:0] word_o
);

    logic              full_w;
    logic [WORD_W-1:0] stop_bit;
    logic [WORD_W-1:0] keep_mask;

    always_comb begin
        full_w    = (nbits_i == CNT_W'(WORD_W));
        stop_bit  = WORD_W'(1) << nbits_i[CNT_W-2:0];
        keep_mask = stop_bit - WORD_W'(1);
        if (full_w) begin
            word_o = word_i;
        end else begin
            word_o = (word_i & keep_mask) | stop_bit;
        end
    end

endmodule

// File: rtl/pad_msg_len.sv
// Running message length in bits.
module pad_msg_len #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W) + 1,
    localparam int LEN_W = 2 * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic             add_last,
    input  logic [CNT_W-1:0] nbits_i,
    input  logic             clr,
    output logic [LEN_W-1:0] len_o
);

    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (clr) begin
            len_q <= '0;
        end else if (add_en) begin
            len_q <= len_q + (add_last ? LEN_W'(nbits_i) : LEN_W'(WORD_W));
        end
    end

    assign len_o = len_q;

    AST_LEN_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !add_last && !clr) |=> (len_o == $past(len_o) + LEN_W'(WORD_W))); // R6

    AST_LEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (len_o == '0)); // R10

endmodule

// File: rtl/pad_blk_idx.sv
// Word position inside the current 16-word block, advanced per output handshake.
module pad_blk_idx #(
    parameter int BLK_WORDS = 16,
    localparam int IDX_W = $clog2(BLK_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx_o,
    output logic [IDX_W-1:0] idx_nxt_o
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx_o     = idx_q;
    assign idx_nxt_o = idx_q + IDX_W'(1);

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (idx_o == $past(idx_nxt_o))); // R5

endmodule

// File: rtl/pad_final_block.sv
module pad_final_block
    import pad_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [WORD_W-1:0]        in_data,
    input  logic                     in_last,
    input  logic [$clog2(WORD_W):0]  in_nbits,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_last
);

    localparam int CNT_W      = $clog2(WORD_W) + 1;
    localparam int LEN_W      = 2 * WORD_W;
    localparam int IDX_W      = $clog2(BLK_WORDS);
    localparam logic [IDX_W-1:0] LEN_LO_IDX = IDX_W'(BLK_WORDS - 2);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(BLK_WORDS - 1);

    pad_state_e        state_q, state_d;
    logic [WORD_W-1:0] tail_word;
    logic [LEN_W-1:0]  msg_len;
    logic [IDX_W-1:0]  idx, idx_nxt;
    logic              in_fire, out_fire, len_clr, tail_full;

    assign in_fire   = (state_q == ST_MSG) && in_valid && out_ready;
    assign out_fire  = out_valid && out_ready;
    assign len_clr   = (state_q == ST_LEN_HI) && out_ready;
    assign tail_full = (in_nbits == CNT_W'(WORD_W));

    pad_tail_mask #(.WORD_W(WORD_W)) u_mask (
        .word_i  (in_data),
        .nbits_i (in_nbits),
        .word_o  (tail_word)
    );

    pad_msg_len #(.WORD_W(WORD_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (in_fire),
        .add_last (in_last),
        .nbits_i  (in_nbits),
        .clr      (len_clr),
        .len_o    (msg_len)
    );

    pad_blk_idx #(.BLK_WORDS(BLK_WORDS)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (out_fire),
        .idx_o     (idx),
        .idx_nxt_o (idx_nxt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MSG;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MSG: begin
                if (in_fire && in_last) begin
                    if (tail_full)                 state_d = ST_ONE;
                    else if (idx_nxt == LEN_LO_IDX) state_d = ST_LEN_LO;
                    else                            state_d = ST_ZERO;
                end
            end
            ST_ONE, ST_ZERO: begin
                if (out_ready) begin
                    state_d = (idx_nxt == LEN_LO_IDX) ? ST_LEN_LO : ST_ZERO;
                end
            end
            ST_LEN_LO: if (out_ready) state_d = ST_LEN_HI;
            ST_LEN_HI: if (out_ready) state_d = ST_MSG;
            default:   state_d = ST_MSG;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b1;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state_q)
            ST_MSG: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_last ? tail_word : in_data;
            end
            ST_ONE:    out_data = WORD_W'(1);
            ST_ZERO:   out_data = '0;
            ST_LEN_LO: out_data = msg_len[WORD_W-1:0];
            ST_LEN_HI: begin
                out_data = msg_len[LEN_W-1:WORD_W];
                out_last = 1'b1;
            end
            default: out_valid = 1'b0;
        endcase
    end

    AST_NBITS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> (in_nbits != '0 && in_nbits <= CNT_W'(WORD_W))); // R3

    AST_LAST_AT_BLOCK_END: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (idx == LAST_IDX)); // R8

    AST_LEN_LO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEN_LO) |-> (idx == LEN_LO_IDX)); // R6

    AST_PAD_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_MSG && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_NEW_MSG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_last) |=> (idx == '0)); // R10

endmodule

// File: tb/sim_pad_final_block.sv
module sim_pad_final_block;

    localparam int PERIOD = 10;
    localparam int QP     = PERIOD / 4;

    typedef struct {
        logic [32:0] v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [5:0]  in_nbits = 6'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    exp_t expq[$];
    int   checks = 0;
    int   fails  = 0;
    bit   throttle = 1'b0;
    bit   hold_off = 1'b0;
    int   msg_no = 0;

    always #(PERIOD/2) clk = ~clk;

    pad_final_block u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_nbits(in_nbits),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(string tag, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (hold_off)      out_ready <= 1'b0;
        else if (throttle) out_ready <= ($urandom % 4) != 0;
        else               out_ready <= 1'b1;
    end

    // Monitor: compare every transferred output word with the scoreboard
    always begin
        exp_t e;
        @(negedge clk);
        #QP;
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                chk("R2 unexpected word", {out_last, out_data}, 33'h0);
            end else begin
                e = expq.pop_front();
                chk(e.tag, {out_last, out_data}, e.v);
            end
        end
    end

    // Drive one word; called at a falling edge, returns at a falling edge
    task automatic put(logic [31:0] w, logic last, logic [5:0] nb);
        bit took;
        in_valid = 1'b1;
        in_data  = w;
        in_last  = last;
        in_nbits = nb;
        took = 1'b0;
        while (!took) begin
            #QP;
            took = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic push(logic last, logic [31:0] d, string tag);
        exp_t e;
        e.v   = {last, d};
        e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic send_msg(int n, int nb, bit stall);
        logic [31:0] words[$];
        logic [31:0] pw;
        logic [63:0] len;
        logic [31:0] d0;
        int          pos;
        int          one_pos;
        bit          extra;
        for (int i = 0; i < n; i++) words.push_back($urandom);
        pos = 0;
        for (int i = 0; i < n - 1; i++) begin
            push(1'b0, words[i], "R2");
            pos++;
        end
        if (nb == 32) begin
            push(1'b0, words[n-1], "R4");
            pos++;
            push(1'b0, 32'h1, "R4");
        end else begin
            pw = (words[n-1] & ((32'h1 << nb) - 32'h1)) | (32'h1 << nb);
            push(1'b0, pw, "R3");
        end
        one_pos = pos;
        pos++;
        extra = (one_pos % 16) >= 14;
        while (pos % 16 != 14) begin
            push(1'b0, 32'h0, extra ? "R7" : "R5");
            pos++;
        end
        len = 64'(32 * (n - 1) + nb);
        push(1'b0, len[31:0], msg_no > 0 ? "R6 R10" : "R6");
        push(1'b1, len[63:32], "R8");
        for (int i = 0; i < n; i++) begin
            put(words[i], i == n - 1, (i == n - 1) ? 6'(nb) : 6'd0);
        end
        #QP;
        chk("R9 in_ready low while padding", {32'h0, in_ready}, 33'h0);
        if (stall) begin
            hold_off = 1'b1;
            @(negedge clk);
            @(negedge clk);
            #QP;
            d0 = out_data;
            @(negedge clk);
            #QP;
            chk("R9 stall holds word", {out_valid, out_data}, {1'b1, d0});
            hold_off = 1'b0;
        end
        @(negedge clk);
        msg_no++;
    endtask

    initial begin
        #(PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #QP;
        chk("R1 out_valid in reset", {32'h0, out_valid}, 33'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #QP;
        chk("R1 idle after reset", {31'h0, out_valid, in_ready}, 33'h1);
        @(negedge clk);

        send_msg(3, 8, 1'b0);    // terminating bit mid-word
        send_msg(1, 32, 1'b0);   // full final word, separate one-bit word
        send_msg(14, 5, 1'b0);   // bit in word 13, length fits
        send_msg(14, 32, 1'b1);  // one-bit word at 14, extra block, stall
        send_msg(16, 1, 1'b0);   // bit in word 15
        send_msg(15, 31, 1'b0);  // bit in word 14
        send_msg(1, 1, 1'b0);
        throttle = 1'b1;
        send_msg(17, 20, 1'b0);  // spans two blocks
        send_msg(16, 32, 1'b0);  // one-bit word opens next block
        send_msg(2, 13, 1'b1);
        throttle = 1'b0;

        for (int i = 0; i < 400 && expq.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", 33'(expq.size()), 33'h0);
        finish_run();
    end

endmodule